// File: doc/BRIEF.md
# Software XON/XOFF Flow Controller

This block performs in-band software flow control for a single serial channel. Software programs four control characters and a 4-bit mode field through a small register write port. The characters are two "resume" codes (on-A, on-B) and two "stop" codes (off-A, off-B). The mode field has two halves. The upper half chooses what the transmitter inserts into its outgoing stream. The lower half chooses what the receiver looks for in its incoming stream.

On the receive side, every character the receiver delivers is passed through, one cycle later, with a flag that marks whether flow control consumed it. A recognised stop pattern raises `tx_paused`. A recognised resume pattern clears it. In two-character receive mode, the first character of a candidate pair is flagged when it arrives, and the pause state changes only when the second character completes the pair.

On the transmit side, a change on the local `near_full` input queues a control character. A rising edge queues the stop code and a falling edge queues the resume code. The queued character is offered to the transmitter through a valid/slot handshake and takes precedence over normal data. In pair mode the two characters go out on consecutive slots.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_paused`, `rx_out_valid`, `rx_out_ctrl` and `tx_ctl_valid` are 0, and the mode field is 0000, so neither direction performs flow control.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` according to `cfg_sel`: 0 stores the mode field (low 4 bits), 1 stores on-A, 2 stores on-B, 3 stores off-A and 4 stores off-B. Selects 5 to 7 change nothing. A write takes effect for characters that arrive in the next cycle and later.
- R3: Each cycle with `rx_valid`=1 gives `rx_out_valid`=1 in the following cycle, with `rx_out_data` equal to the received character. With receive mode bits [1:0]=00, `rx_out_ctrl` stays 0 and `tx_paused` is unchanged.
- R4: Receive bits [1:0]=10 match only on-A and off-A. Receive bits [1:0]=01 match only on-B and off-B.
- R5: With receive bits 11 and transmit bits [3:2] equal to 10 or 01, either off code counts as a stop and either on code counts as a resume.
- R6: With receive bits 11 and transmit bits equal to 11 or 00, a stop is off-A followed by off-B on the next received character, and a resume is on-A followed by on-B. Both characters of the pair are flagged, and `tx_paused` changes with the second one.
- R7: In pair mode, a received character that does not complete a pending pair drops the partial match and is checked again as a possible first character. Writing the mode field also drops any partial match.
- R8: A recognised stop sets `tx_paused` and a recognised resume clears it. Both are flagged with `rx_out_ctrl`=1. When one character matches both a stop and a resume code, the stop wins.
- R9: In the cycle after `near_full` rises, a stop request is offered on `tx_ctl_valid`/`tx_ctl_char`. In the cycle after it falls, a resume request is offered. With transmit bits 00, edges queue nothing.
- R10: Transmit bits 10 send the A code of the queued kind, and transmit bits 01 send the B code.
- R11: An offered character stays valid and unchanged until a cycle with `tx_slot`=1 takes it. In pair mode (transmit bits 11), the A code is taken first, and the B code is offered in the very next cycle.
- R12: A new `near_full` edge replaces any pending request and restarts it with the first character, even in a cycle where `tx_slot` takes the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 mode, 1 on-A, 2 on-B, 3 off-A, 4 off-B) |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_out_valid | output | 1 | Delayed received character valid |
| rx_out_data | output | 8 | Delayed received character |
| rx_out_ctrl | output | 1 | Character consumed by flow control; do not forward |
| tx_paused | output | 1 | Far end asked the transmitter to stop |
| near_full | input | 1 | Local receive buffer nearly full |
| tx_slot | input | 1 | Transmitter takes the offered control character this cycle |
| tx_ctl_valid | output | 1 | Control character waiting for insertion |
| tx_ctl_char | output | 8 | Control character to insert |

## Verification
The transmit queue can see a new `near_full` edge in the same cycle that `tx_slot` takes its current character. It can also see that edge in the same cycle that the first character of a pair is taken. The bench forces both collisions on purpose, and also hits them at random with `near_full` and `tx_slot` toggling often. The expected result is that the new request wins and restarts with its first character. In the same way, the receive side gets mode writes in the same cycle that a pair's first character arrives, and the partial match must be dropped.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  // register select codes
  localparam int SEL_MODE  = 0;
  localparam int SEL_ON_A  = 1;
  localparam int SEL_ON_B  = 2;
  localparam int SEL_OFF_A = 3;
  localparam int SEL_OFF_B = 4;
  localparam int NUM_CHARS = 4;
  localparam int MODE_W    = 4;

  // index of each control character inside the character bank
  localparam int IDX_ON_A  = 0;
  localparam int IDX_ON_B  = 1;
  localparam int IDX_OFF_A = 2;
  localparam int IDX_OFF_B = 3;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON   = 2'd1,
    PEND_OFF  = 2'd2
  } pend_e;
endpackage

// File: rtl/swfc_cfg_regs.sv
module swfc_cfg_regs
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CHAR_W-1:0] wdata,
  output logic [MODE_W-1:0] mode,
  output logic [CHAR_W-1:0] chars [NUM_CHARS],
  output logic              mode_wr
);
  assign mode_wr = we && (sel == SEL_W'(SEL_MODE));

  always_ff @(posedge clk) begin
    if (rst)          mode <= '0;
    else if (mode_wr) mode <= wdata[MODE_W-1:0];
  end

  // character k lives at select code k+1
  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
    always_ff @(posedge clk) begin
      if (rst)
        chars[k] <= '0;
      else if (we && (sel == SEL_W'(k + 1)))
        chars[k] <= wdata;
    end
  end
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [CHAR_W-1:0] chars [NUM_CHARS],
  input  logic              mode_wr,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_ctrl,
  output logic              paused
);
  logic [1:0] rx_bits, tx_bits;
  logic       either_mode, pair_mode;
  logic       hit_on_a, hit_on_b, hit_off_a, hit_off_b;
  logic       do_off, do_on, do_flag;
  pend_e      pend_q, pend_d;

  assign rx_bits     = mode[1:0];
  assign tx_bits     = mode[3:2];
  assign either_mode = (rx_bits == 2'b11) && (tx_bits == 2'b10 || tx_bits == 2'b01);
  assign pair_mode   = (rx_bits == 2'b11) && !either_mode;

  assign hit_on_a  = (in_char == chars[IDX_ON_A]);
  assign hit_on_b  = (in_char == chars[IDX_ON_B]);
  assign hit_off_a = (in_char == chars[IDX_OFF_A]);
  assign hit_off_b = (in_char == chars[IDX_OFF_B]);

  always_comb begin
    do_off  = 1'b0;
    do_on   = 1'b0;
    do_flag = 1'b0;
    pend_d  = PEND_NONE;
    if (in_valid) begin
      if (pair_mode) begin
        if (pend_q == PEND_OFF && hit_off_b) begin
          do_off  = 1'b1;
          do_flag = 1'b1;
        end else if (pend_q == PEND_ON && hit_on_b) begin
          do_on   = 1'b1;
          do_flag = 1'b1;
        end else if (hit_off_a) begin
          pend_d  = PEND_OFF;
          do_flag = 1'b1;
        end else if (hit_on_a) begin
          pend_d  = PEND_ON;
          do_flag = 1'b1;
        end
      end else begin
        unique case (rx_bits)
          2'b10: begin do_off = hit_off_a;              do_on = hit_on_a;             end
          2'b01: begin do_off = hit_off_b;              do_on = hit_on_b;             end
          2'b11: begin do_off = hit_off_a || hit_off_b; do_on = hit_on_a || hit_on_b; end
          default: begin do_off = 1'b0;                 do_on = 1'b0;                 end
        endcase
        do_flag = do_off || do_on;
      end
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= PEND_NONE;
      paused    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= 1'b0;
    end else begin
      pend_q    <= mode_wr ? PEND_NONE : pend_d;
      out_valid <= in_valid;
      out_data  <= in_char;
      out_ctrl  <= do_flag;
      if (do_off)     paused <= 1'b1;
      else if (do_on) paused <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        tx_bits,
  input  logic [CHAR_W-1:0] chars [NUM_CHARS],
  input  logic              near_full,
  input  logic              slot,
  output logic              ctl_valid,
  output logic [CHAR_W-1:0] ctl_char
);
  logic              nf_q;
  logic              rise, fall, kick;
  logic              kind_off, pair, second;
  logic [CHAR_W-1:0] first_char;

  // tracks the input every cycle, reset or not, so edges line up with the pin history
  always_ff @(posedge clk) nf_q <= near_full;

  assign rise = near_full && !nf_q;
  assign fall = !near_full && nf_q;
  assign kick = (rise || fall) && (tx_bits != 2'b00);

  always_comb begin
    if (tx_bits == 2'b01) first_char = rise ? chars[IDX_OFF_B] : chars[IDX_ON_B];
    else                  first_char = rise ? chars[IDX_OFF_A] : chars[IDX_ON_A];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_valid <= 1'b0;
      ctl_char  <= '0;
      kind_off  <= 1'b0;
      pair      <= 1'b0;
      second    <= 1'b0;
    end else if (kick) begin
      ctl_valid <= 1'b1;
      ctl_char  <= first_char;
      kind_off  <= rise;
      pair      <= (tx_bits == 2'b11);
      second    <= 1'b0;
    end else if (ctl_valid && slot) begin
      if (pair && !second) begin
        second   <= 1'b1;
        ctl_char <= kind_off ? chars[IDX_OFF_B] : chars[IDX_ON_B];
      end else begin
        ctl_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_out_valid,
  output logic [CHAR_W-1:0] rx_out_data,
  output logic              rx_out_ctrl,
  output logic              tx_paused,
  input  logic              near_full,
  input  logic              tx_slot,
  output logic              tx_ctl_valid,
  output logic [CHAR_W-1:0] tx_ctl_char
);
  logic [MODE_W-1:0] mode;
  logic [CHAR_W-1:0] chars [NUM_CHARS];
  logic              mode_wr;

  swfc_cfg_regs #(.CHAR_W(CHAR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .mode(mode), .chars(chars), .mode_wr(mode_wr)
  );

  swfc_rx_match #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst(rst), .mode(mode), .chars(chars), .mode_wr(mode_wr),
    .in_valid(rx_valid), .in_char(rx_char),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .out_ctrl(rx_out_ctrl),
    .paused(tx_paused)
  );

  swfc_tx_insert #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst(rst), .tx_bits(mode[3:2]), .chars(chars),
    .near_full(near_full), .slot(tx_slot),
    .ctl_valid(tx_ctl_valid), .ctl_char(tx_ctl_char)
  );
endmodule

// File: rtl/swfc_chk.sv
module swfc_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_char,
  input logic              rx_out_valid,
  input logic [CHAR_W-1:0] rx_out_data,
  input logic              rx_out_ctrl,
  input logic              tx_paused,
  input logic              near_full,
  input logic              tx_slot,
  input logic              tx_ctl_valid,
  input logic [CHAR_W-1:0] tx_ctl_char
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !tx_paused && !tx_ctl_valid && !rx_out_valid);

  // R3
  rx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_out_valid && rx_out_data == $past(rx_char));

  // R3
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !rx_out_valid && !rx_out_ctrl);

  // R8
  pause_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_paused) |-> rx_out_valid && rx_out_ctrl);

  // R9
  req_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ctl_valid) |-> $past(near_full) != $past(near_full, 2));

  // R11
  hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ctl_valid && !tx_slot && near_full == $past(near_full)
    |=> tx_ctl_valid && $stable(tx_ctl_char));
endmodule

bind xonxoff_flow_ctrl swfc_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
  .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ctrl(rx_out_ctrl),
  .tx_paused(tx_paused), .near_full(near_full), .tx_slot(tx_slot),
  .tx_ctl_valid(tx_ctl_valid), .tx_ctl_char(tx_ctl_char)
);

// File: tb/xonxoff_flow_ctrl_test.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic       near_full = 1'b0;
  logic       tx_slot = 1'b0;
  logic       rx_out_valid, rx_out_ctrl, tx_paused, tx_ctl_valid;
  logic [7:0] rx_out_data, tx_ctl_char;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string rx_req = "R1";
  string tx_req = "R1";

  always #2.5 clk = ~clk;

  xonxoff_flow_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ctrl(rx_out_ctrl),
    .tx_paused(tx_paused), .near_full(near_full), .tx_slot(tx_slot),
    .tx_ctl_valid(tx_ctl_valid), .tx_ctl_char(tx_ctl_char)
  );

  // reference model state; chars: 0 on-A, 1 on-B, 2 off-A, 3 off-B
  logic [3:0] m_mode;
  logic [7:0] m_ch [4];
  logic       m_paused, m_ov, m_oc, m_tv, m_koff, m_pair, m_sec, m_nfq;
  logic [7:0] m_od, m_tc;
  int         m_pend; // 0 none, 1 on, 2 off

  function automatic logic [7:0] first_code(input logic [1:0] tb, input logic off);
    if (tb == 2'b01) return off ? m_ch[3] : m_ch[1];
    return off ? m_ch[2] : m_ch[0];
  endfunction

  task automatic model_step();
    logic [1:0] rb, tb;
    logic       either, pair, on_hit, off_hit, rise, fall;
    int         np;
    rb = m_mode[1:0];
    tb = m_mode[3:2];
    if (rst) begin
      m_mode = '0; m_paused = 0; m_ov = 0; m_oc = 0; m_od = '0; m_pend = 0;
      m_tv = 0; m_tc = '0; m_koff = 0; m_pair = 0; m_sec = 0;
      for (int k = 0; k < 4; k++) m_ch[k] = '0;
      m_nfq = near_full;
      return;
    end
    either = (rb == 2'b11) && (tb == 2'b10 || tb == 2'b01);
    pair = (rb == 2'b11) && !either;
    m_ov = rx_valid; m_od = rx_char; m_oc = 0;
    np = rx_valid ? 0 : m_pend;
    if (rx_valid) begin
      if (pair) begin
        if (m_pend == 2 && rx_char == m_ch[3]) begin m_paused = 1; m_oc = 1; end
        else if (m_pend == 1 && rx_char == m_ch[1]) begin m_paused = 0; m_oc = 1; end
        else if (rx_char == m_ch[2]) begin np = 2; m_oc = 1; end
        else if (rx_char == m_ch[0]) begin np = 1; m_oc = 1; end
      end else begin
        off_hit = (rb[1] && rx_char == m_ch[2]) || (rb[0] && rx_char == m_ch[3]);
        on_hit  = (rb[1] && rx_char == m_ch[0]) || (rb[0] && rx_char == m_ch[1]);
        if (off_hit) begin m_paused = 1; m_oc = 1; end
        else if (on_hit) begin m_paused = 0; m_oc = 1; end
      end
    end
    m_pend = np;
    // transmit side
    rise = near_full && !m_nfq;
    fall = !near_full && m_nfq;
    if ((rise || fall) && tb != 2'b00) begin
      m_tv = 1; m_koff = rise; m_sec = 0; m_pair = (tb == 2'b11);
      m_tc = first_code(tb, rise);
    end else if (m_tv && tx_slot) begin
      if (m_pair && !m_sec) begin m_sec = 1; m_tc = m_koff ? m_ch[3] : m_ch[1]; end
      else m_tv = 0;
    end
    m_nfq = near_full;
    // register writes land last
    if (cfg_we) begin
      if (cfg_sel == 3'd0) begin m_mode = cfg_wdata[3:0]; m_pend = 0; end
      else if (cfg_sel >= 3'd1 && cfg_sel <= 3'd4) m_ch[cfg_sel - 3'd1] = cfg_wdata;
    end
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(rx_req, "rx_out", {5'b0, rx_out_valid, rx_out_ctrl, tx_paused, (rx_out_valid ? rx_out_data : 8'h00)},
                            {5'b0, m_ov, m_oc, m_paused, (m_ov ? m_od : 8'h00)});
    check(tx_req, "tx_ctl", {7'b0, tx_ctl_valid, (tx_ctl_valid ? tx_ctl_char : 8'h00)},
                            {7'b0, m_tv, (m_tv ? m_tc : 8'h00)});
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  task automatic rxc(input logic [7:0] c);
    rx_valid = 1; rx_char = c;
    cyc();
    rx_valid = 0;
  endtask

  task automatic set_req(input string r);
    rx_req = r; tx_req = r;
  endtask

  initial begin
    m_mode = '0;
    m_paused = 0;
    m_pend = 0;
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    set_req("R1");
    cyc();

    set_req("R2");
    wr(3'd1, 8'h11); wr(3'd2, 8'h91); wr(3'd3, 8'h13); wr(3'd4, 8'h93);
    wr(3'd5, 8'h42); wr(3'd7, 8'h42);
    set_req("R3");
    rxc(8'h13); rxc(8'h42); rxc(8'h11);

    set_req("R4");
    wr(3'd0, 8'h02); rxc(8'h93); rxc(8'h13); rxc(8'h91); rxc(8'h11);
    wr(3'd0, 8'h01); rxc(8'h13); rxc(8'h93); rxc(8'h91);

    set_req("R5");
    wr(3'd0, 8'h0B); rxc(8'h93); rxc(8'h11); rxc(8'h13); rxc(8'h91);

    set_req("R6");
    wr(3'd0, 8'h03); rxc(8'h13); rxc(8'h93); rxc(8'h11); rxc(8'h91);

    set_req("R7");
    rxc(8'h11); rxc(8'h13); rxc(8'h93);
    rxc(8'h11); rxc(8'h55); rxc(8'h91);
    rx_valid = 1; rx_char = 8'h11; cfg_we = 1; cfg_sel = 3'd0; cfg_wdata = 8'h03;
    cyc(); rx_valid = 0; cfg_we = 0;
    rxc(8'h91);

    set_req("R8");
    wr(3'd0, 8'h02); wr(3'd3, 8'h11); rxc(8'h11); rxc(8'h11);
    wr(3'd3, 8'h13);

    set_req("R9");
    wr(3'd0, 8'h08);
    near_full = 1; cyc(); cyc(); cyc();
    tx_slot = 1; cyc(); tx_slot = 0;
    near_full = 0; cyc(); tx_slot = 1; cyc(); tx_slot = 0;
    wr(3'd0, 8'h00); near_full = 1; cyc(); cyc(); near_full = 0; cyc();

    set_req("R10");
    wr(3'd0, 8'h04); near_full = 1; cyc(); tx_slot = 1; cyc(); tx_slot = 0;
    near_full = 0; cyc(); tx_slot = 1; cyc(); tx_slot = 0;

    set_req("R11");
    wr(3'd0, 8'h0C); near_full = 1; cyc(); cyc();
    tx_slot = 1; cyc(); cyc(); cyc(); tx_slot = 0;

    set_req("R12");
    near_full = 0; cyc(); near_full = 1; cyc();
    tx_slot = 1; near_full = 0; cyc();
    near_full = 1; cyc(); cyc(); cyc(); tx_slot = 0;

    // random mix
    rx_req = "R3"; tx_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] pool [5];
      pool[0] = 8'h11; pool[1] = 8'h91; pool[2] = 8'h13; pool[3] = 8'h93; pool[4] = 8'($urandom);
      r = $urandom_range(0, 99);
      cfg_we = (r < 6);
      cfg_sel = 3'($urandom_range(0, 7));
      cfg_wdata = (cfg_sel == 3'd0) ? 8'($urandom) : pool[$urandom_range(0, 4)];
      rx_valid = ($urandom_range(0, 2) != 0);
      rx_char = pool[$urandom_range(0, 4)];
      if ($urandom_range(0, 5) == 0) near_full = ~near_full;
      tx_slot = ($urandom_range(0, 2) == 0);
      cyc();
    end
    cfg_we = 0; rx_valid = 0; tx_slot = 0;
    cyc();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule